// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits between a synchronous memory request port and an asynchronous fast-page-mode DRAM. It turns each request into the strobe sequence the memory needs. The row half of the address goes out on a shared address bus when the row strobe falls. The column half follows when the column strobe falls. Read data is latched at the end of the column strobe and handed back with a one-cycle word-valid pulse. After an access the row stays open. A later request to the same row only pulses the column strobe, while a request to a different row closes the page, waits out the precharge time and then opens the new row.

A request can be a single read, a single write, or a four-word line-fill read. A line fill keeps the row open and pulses the column strobe four times. It walks the two low column bits around the aligned group of four, beginning at the requested word. A free-running timer asks for one row refresh per interval. A pending refresh blocks new requests, closes any open page, precharges, and then runs a row-strobe-only cycle on the next row from a wrapping row counter.

All timing values are counted in clock cycles and set by parameters. The defaults assume a 30 ns clock, with each value rounded up.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset all four strobes (ras_n, cas_n, we_n, oe_n) are high, rd_valid is low and req_ready is high.
- R2: A single read places the row on dram_addr when ras_n falls and the column when cas_n falls. oe_n is low and we_n is high while cas_n is low. The addressed word comes back on rd_data with a one-cycle rd_valid pulse.
- R3: On a write, we_n is low at least one cycle before cas_n falls and stays low while cas_n is low. oe_n stays high, and the word from req_wdata is stored at the addressed location.
- R4: A request to the row that is already open causes no ras_n edge; only cas_n pulses.
- R5: Each time ras_n falls, it has been high for at least T_RP cycles beforehand. This covers a change of row while a page is open.
- R6: A read with req_burst set returns four words with ras_n held low. The column order is c, then c+1, c+2 and c+3, each taken modulo 4 within the aligned group of four; the upper column bits do not change.
- R7: req_burst has no effect on a write: exactly one cas_n pulse occurs and only the addressed word changes.
- R8: A refresh strobes ras_n with no cas_n pulse. Successive refreshes start REF_INTERVAL cycles apart, shifted by at most the length of one access.
- R9: Refresh rows start at 0 after reset, rise by one per refresh, and wrap from 2**AW-1 to 0.
- R10: A refresh that falls due during an access lets that access finish. It then takes priority over the next request, closing the open page and precharging for T_RP cycles before the refresh strobe.
- R11: cas_n is low only while ras_n is low, and dram_addr does not change while cas_n stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when req_valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-word line-fill read |
| req_addr | input | 2*AW | Row in the upper AW bits, column in the lower AW bits |
| req_wdata | input | DW | Write word |
| rd_valid | output | 1 | One-cycle pulse for each returned read word |
| rd_data | output | DW | Returned read word |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | AW | Multiplexed row/column address |
| dram_dq_o | output | DW | Write data to the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | DW | Read data from the memory |

## Verification
A refresh and a line fill can be due in the same cycle. The refresh timer expires while the fill is still pulsing its column strobe, and the next read is already queued behind it. The bench aligns itself to an observed refresh and then starts a fill so that the timer expires mid-burst. It then checks three things: the four words arrive with no row strobe rise between them, the refresh row comes next, and the queued same-row read needs a fresh row opening instead of a page hit. A memory model in the bench also judges every row-strobe fall against the precharge minimum and checks every refresh row number.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW,
        S_COL,
        S_CAS,
        S_PRE,
        S_REF
    } fpm_state_e;

    typedef enum logic [1:0] {
        AP_IDLE,
        AP_ROW,
        AP_REF
    } fpm_after_e;
endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
    parameter int INTERVAL = 520,
    parameter int ROW_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pend,
    output logic [ROW_W-1:0] row
);
    localparam int CW = $clog2(INTERVAL + 1);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic             pend;
        logic [ROW_W-1:0] row;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (q.cnt == CW'(INTERVAL - 1)) begin
            d.cnt  = '0;
            d.pend = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        if (ack) begin
            d.pend = 1'b0;
            d.row  = q.row + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;
    assign row  = q.row;
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DW    = 16,
    parameter int T_RCD = 1,
    parameter int T_CAS = 1,
    parameter int T_RP  = 2,
    parameter int T_RAS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_burst,
    input  logic [AW-1:0] req_row,
    input  logic [AW-1:0] req_col,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          ref_pend,
    input  logic [AW-1:0] ref_row,
    output logic          ref_ack,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          oe_n,
    output logic [AW-1:0] dram_addr,
    output logic [DW-1:0] dram_dq_o,
    output logic          dram_dq_oe,
    input  logic [DW-1:0] dram_dq_i
);
    localparam int TM1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int TM2   = (T_RP > T_RAS) ? T_RP : T_RAS;
    localparam int TMAX  = (TM1 > TM2) ? TM1 : TM2;
    localparam int CNT_W = $clog2(TMAX + 1);

    typedef struct packed {
        fpm_state_e     st;
        fpm_after_e     ap;
        logic [CNT_W-1:0] cnt;
        logic           open;
        logic [AW-1:0]  orow;
        logic [AW-1:0]  col;
        logic           wr;
        logic [DW-1:0]  wdata;
        logic [1:0]     left;
        logic           ras_n;
        logic           cas_n;
        logic           we_n;
        logic           oe_n;
        logic [AW-1:0]  addr;
        logic           rdv;
        logic [DW-1:0]  rdata;
        logic           ack;
    } seq_t;

    seq_t q, d;

    assign req_ready = (q.st == S_IDLE) && !ref_pend;

    always_comb begin
        d     = q;
        d.rdv = 1'b0;
        d.ack = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (ref_pend) begin
                    if (q.open) begin
                        d.ras_n = 1'b1;
                        d.open  = 1'b0;
                        d.st    = S_PRE;
                        d.ap    = AP_REF;
                        d.cnt   = CNT_W'(T_RP - 1);
                    end else begin
                        d.st    = S_REF;
                        d.ras_n = 1'b0;
                        d.addr  = ref_row;
                        d.cnt   = CNT_W'(T_RAS - 1);
                        d.ack   = 1'b1;
                    end
                end else if (req_valid) begin
                    d.wr    = req_write;
                    d.wdata = req_wdata;
                    d.col   = req_col;
                    d.left  = (req_burst && !req_write) ? 2'd3 : 2'd0;
                    d.orow  = req_row;
                    if (q.open && q.orow == req_row) begin
                        d.st   = S_COL;
                        d.addr = req_col;
                        d.we_n = !req_write;
                        d.oe_n = req_write;
                    end else if (q.open) begin
                        d.ras_n = 1'b1;
                        d.open  = 1'b0;
                        d.st    = S_PRE;
                        d.ap    = AP_ROW;
                        d.cnt   = CNT_W'(T_RP - 1);
                    end else begin
                        d.st    = S_ROW;
                        d.ras_n = 1'b0;
                        d.open  = 1'b1;
                        d.addr  = req_row;
                        d.cnt   = CNT_W'(T_RCD - 1);
                    end
                end
            end
            S_ROW: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.st   = S_COL;
                    d.addr = q.col;
                    d.we_n = !q.wr;
                    d.oe_n = q.wr;
                end
            end
            S_COL: begin
                d.st    = S_CAS;
                d.cas_n = 1'b0;
                d.cnt   = CNT_W'(T_CAS - 1);
            end
            S_CAS: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.cas_n = 1'b1;
                    d.rdv   = !q.wr;
                    d.rdata = dram_dq_i;
                    if (q.left != 2'd0) begin
                        d.left = q.left - 1'b1;
                        d.col  = {q.col[AW-1:2], q.col[1:0] + 2'd1};
                        d.addr = d.col;
                        d.st   = S_COL;
                    end else begin
                        d.st   = S_IDLE;
                        d.we_n = 1'b1;
                        d.oe_n = 1'b1;
                    end
                end
            end
            S_PRE: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    case (q.ap)
                        AP_ROW: begin
                            d.st    = S_ROW;
                            d.ras_n = 1'b0;
                            d.open  = 1'b1;
                            d.addr  = q.orow;
                            d.cnt   = CNT_W'(T_RCD - 1);
                        end
                        AP_REF: begin
                            d.st    = S_REF;
                            d.ras_n = 1'b0;
                            d.addr  = ref_row;
                            d.cnt   = CNT_W'(T_RAS - 1);
                            d.ack   = 1'b1;
                        end
                        default: d.st = S_IDLE;
                    endcase
                end
            end
            S_REF: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.ras_n = 1'b1;
                    d.st    = S_PRE;
                    d.ap    = AP_IDLE;
                    d.cnt   = CNT_W'(T_RP - 1);
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.ap    <= AP_IDLE;
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
            q.we_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_valid   = q.rdv;
    assign rd_data    = q.rdata;
    assign ref_ack    = q.ack;
    assign ras_n      = q.ras_n;
    assign cas_n      = q.cas_n;
    assign we_n       = q.we_n;
    assign oe_n       = q.oe_n;
    assign dram_addr  = q.addr;
    assign dram_dq_o  = q.wdata;
    assign dram_dq_oe = !q.we_n;
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
    parameter int AW           = 10,
    parameter int DW           = 16,
    parameter int T_RCD        = 1,
    parameter int T_CAS        = 1,
    parameter int T_RP         = 2,
    parameter int T_RAS        = 2,
    parameter int REF_INTERVAL = 520
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic            req_burst,
    input  logic [2*AW-1:0] req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic            ras_n,
    output logic            cas_n,
    output logic            we_n,
    output logic            oe_n,
    output logic [AW-1:0]   dram_addr,
    output logic [DW-1:0]   dram_dq_o,
    output logic            dram_dq_oe,
    input  logic [DW-1:0]   dram_dq_i
);
    logic          ref_pend;
    logic          ref_ack;
    logic [AW-1:0] ref_row;

    fpm_refresh_timer #(
        .INTERVAL (REF_INTERVAL),
        .ROW_W    (AW)
    ) tmr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .ack  (ref_ack),
        .pend (ref_pend),
        .row  (ref_row)
    );

    fpm_seq #(
        .AW   (AW),
        .DW   (DW),
        .T_RCD(T_RCD),
        .T_CAS(T_CAS),
        .T_RP (T_RP),
        .T_RAS(T_RAS)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_burst (req_burst),
        .req_row   (req_addr[2*AW-1:AW]),
        .req_col   (req_addr[AW-1:0]),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .ref_pend  (ref_pend),
        .ref_row   (ref_row),
        .ref_ack   (ref_ack),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .dram_addr (dram_addr),
        .dram_dq_o (dram_dq_o),
        .dram_dq_oe(dram_dq_oe),
        .dram_dq_i (dram_dq_i)
    );
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
    parameter int AW   = 10,
    parameter int T_RP = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic          oe_n,
    input logic [AW-1:0] dram_addr
);
    localparam int HW = $clog2(T_RP + 2);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                  hi_cnt <= HW'(T_RP);
        else if (!ras_n)             hi_cnt <= '0;
        else if (hi_cnt < HW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);                                               // R11
    AST_ADDR_HELD_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> $stable(dram_addr));                // R11
    AST_WE_LEADS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> $past(!we_n));                        // R3
    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));                                               // R2
    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= HW'(T_RP)));                          // R5
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.AW(AW), .T_RP(T_RP)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dram_addr(dram_addr)
);

// File: tb/fpm_dram_ctrl_tb_top.sv
module fpm_dram_ctrl_tb_top;
    localparam int AW   = 10;
    localparam int DW   = 16;
    localparam int T_RP = 2;
    localparam int RI   = 100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [2*AW-1:0] req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dram_dq_oe;
    logic [DW-1:0]   rd_data, dram_dq_o;
    logic [DW-1:0]   dram_dq_i = '0;
    logic [AW-1:0]   dram_addr;

    always #4 clk = ~clk;

    fpm_dram_ctrl #(.AW(AW), .DW(DW), .T_RP(T_RP), .REF_INTERVAL(RI)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .dram_addr(dram_addr), .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe),
        .dram_dq_i(dram_dq_i)
    );

    int vec = 0, bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model
    logic [DW-1:0] mem [int];
    function automatic logic [DW-1:0] pat(input int r, input int c);
        return DW'({r[5:0], c[9:0]}) ^ 16'h5A3C;
    endfunction
    function automatic logic [DW-1:0] look(input int r, input int c);
        if (mem.exists(r * 1024 + c)) return mem[r * 1024 + c];
        return pat(r, c);
    endfunction

    logic pras = 1'b1, pcas = 1'b1, pwe = 1'b1;
    int row_lat = 0, hi_cnt = 100, ras_falls = 0, cas_falls = 0;
    int ref_cnt = 0, exp_ref = 0, fall_t = 0, last_ref_t = 0;
    bit cas_seen = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pras && !ras_n) begin
                chk(hi_cnt >= T_RP, "R5 precharge", hi_cnt, T_RP);
                row_lat = int'(dram_addr);
                cas_seen = 1'b0;
                fall_t = cyc;
                ras_falls++;
            end
            if (!pras && ras_n && !cas_seen) begin
                chk(row_lat == exp_ref, "R9 refresh row", row_lat, exp_ref);
                exp_ref = (exp_ref + 1) % 1024;
                if (ref_cnt > 0)
                    chk((fall_t - last_ref_t) <= RI + 20 && (fall_t - last_ref_t) >= RI - 20,
                        "R8 refresh spacing", fall_t - last_ref_t, RI);
                last_ref_t = fall_t;
                ref_cnt++;
            end
            if (pcas && !cas_n) begin
                cas_falls++;
                cas_seen = 1'b1;
                if (!we_n) chk(!pwe && oe_n, "R3 we before cas", pwe, 0);
                if (ras_n) chk(1'b0, "R11 cas without ras", ras_n, 0);
            end
            if (!cas_n && !we_n) mem[row_lat * 1024 + int'(dram_addr)] = dram_dq_o;
            if (!cas_n && !oe_n) dram_dq_i = look(row_lat, int'(dram_addr));
            hi_cnt = ras_n ? hi_cnt + 1 : 0;
            pras = ras_n; pcas = cas_n; pwe = we_n;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            chk(1'b0, "watchdog", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    task automatic issue(input bit w, input bit b, input int r, input int c, input logic [DW-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_burst = b;
        req_addr = {AW'(r), AW'(c)}; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic get_word(output logic [DW-1:0] v);
        int t = 0;
        v = '0;
        while (t < 200) begin
            if (rd_valid) begin v = rd_data; break; end
            @(negedge clk); t++;
        end
        chk(t < 200, "R2 read returned", t, 0);
        @(negedge clk);
    endtask

    task automatic wait_idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sync_refresh();
        int n = ref_cnt;
        while (ref_cnt == n) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high", {ras_n, cas_n, we_n, oe_n}, 4'hF);
        chk(req_ready, "R1 ready", req_ready, 1);
        chk(!rd_valid, "R1 rd_valid low", rd_valid, 0);
    endtask

    task automatic t_read_write_page();
        logic [DW-1:0] v;
        int rf;
        sync_refresh();
        issue(0, 0, 3, 17, '0);
        get_word(v);
        chk(v == pat(3, 17), "R2 single read", v, pat(3, 17));
        issue(1, 0, 3, 40, 16'hBEEF);
        wait_idle(3);
        rf = ras_falls;
        issue(0, 0, 3, 40, '0);
        get_word(v);
        chk(v == 16'hBEEF, "R3 write readback", v, 16'hBEEF);
        chk(ras_falls == rf, "R4 page hit no ras edge", ras_falls, rf);
        issue(0, 0, 9, 2, '0);
        get_word(v);
        chk(v == pat(9, 2), "R5 row miss data", v, pat(9, 2));
        chk(ras_falls == rf + 1, "R5 row reopened", ras_falls, rf + 1);
    endtask

    task automatic t_burst();
        logic [DW-1:0] v;
        int rf, cf;
        int ord[4] = '{6, 7, 4, 5};
        sync_refresh();
        rf = ras_falls; cf = cas_falls;
        issue(0, 1, 12, 6, '0);
        for (int i = 0; i < 4; i++) begin
            get_word(v);
            chk(v == pat(12, ord[i]), "R6 burst word order", v, pat(12, ord[i]));
        end
        chk(ras_falls == rf + 1, "R6 ras held", ras_falls, rf + 1);
        chk(cas_falls == cf + 4, "R6 four cas pulses", cas_falls, cf + 4);
        cf = cas_falls;
        issue(1, 1, 12, 9, 16'h1234);
        wait_idle(4);
        chk(cas_falls == cf + 1, "R7 write burst single cas", cas_falls, cf + 1);
        issue(0, 0, 12, 10, '0);
        get_word(v);
        chk(v == pat(12, 10), "R7 neighbour untouched", v, pat(12, 10));
        issue(0, 0, 12, 9, '0);
        get_word(v);
        chk(v == 16'h1234, "R7 written word", v, 16'h1234);
    endtask

    task automatic t_collision();
        logic [DW-1:0] v;
        int rf, rc;
        sync_refresh();
        wait_idle(90);
        rf = ras_falls; rc = ref_cnt;
        issue(0, 1, 20, 0, '0);
        for (int i = 0; i < 4; i++) begin
            get_word(v);
            chk(v == pat(20, i), "R10 burst intact", v, pat(20, i));
        end
        chk(ref_cnt == rc, "R10 no refresh inside burst", ref_cnt, rc);
        issue(0, 0, 20, 3, '0);
        get_word(v);
        chk(v == pat(20, 3), "R10 queued read data", v, pat(20, 3));
        chk(ref_cnt == rc + 1, "R10 refresh before next request", ref_cnt, rc + 1);
        chk(ras_falls == rf + 3, "R10 page closed by refresh", ras_falls, rf + 3);
    endtask

    task automatic t_sweep();
        while (ref_cnt < 1030) @(negedge clk);
        chk(exp_ref == 1030 % 1024, "R9 counter wrapped", exp_ref, 1030 % 1024);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_write_page();
        t_burst();
        t_collision();
        t_sweep();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule